// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block gathers single-cycle event pulses from a network receive/transmit datapath and keeps them in a sticky cause register. A separate mask register selects which causes may reach the processor. One registered interrupt line goes high while any enabled cause is pending. Software uses a small strobe-based register bus to enable and disable causes, read and acknowledge them, and inject causes for test.

The bus has one write strobe and one read strobe, a two-bit word address and 32-bit data. Address 0 is the cause view: a read returns the pending causes, with bit 31 showing the interrupt line, and a write clears causes. Address 1 injects causes. Address 2 sets mask bits, and a read there returns the mask. Address 3 clears mask bits. Read data is registered and shows the state as it was in the cycle of the read strobe.

Top module: `irq_cause_ctrl`

## Requirements
- R1: Only cause bits 0, 1, 2, 4, 6, 7, 9, 15, 16 and 17 exist (valid mask 0x000382D7). Cause and mask bits 3, 5, 8, 10 to 14 and 18 to 30 always read 0, and events or writes to them have no effect.
- R2: A write to address 2 sets every existing mask bit that is written with 1 and leaves the others unchanged. A read of address 2 returns the mask.
- R3: A write to address 3 clears every mask bit that is written with 1 and leaves the others unchanged.
- R4: A one-cycle high pulse on an existing bit of `evt_in` sets the matching cause bit, which then stays set until it is cleared.
- R5: A write to address 0 clears every cause bit written with 1. Bits written with 0 are unchanged, and writing bit 31 has no effect.
- R6: A write to address 1 sets every existing cause bit written with 1, just as an event would. An injected cause raises the interrupt only if its mask bit is set.
- R7: `irq_o` is the OR over bits 0 to 30 of cause AND mask, taken from a register. It changes one clock cycle after the cause or mask register changes.
- R8: Bit 31 of a read of address 0 is the value of `irq_o` in the cycle of the read strobe.
- R9: A read of address 0 while `irq_o` is 0 clears the whole cause register. A read while `irq_o` is 1 leaves the cause register unchanged.
- R10: If an event pulse and a clearing write to address 0 hit the same bit in the same cycle, the bit stays set.
- R11: While `rst` is high, the mask, the cause register, `irq_o` and `bus_rdata` are all 0.
- R12: `bus_rdata` is updated in the cycle after a read strobe and holds its value until the next read. Reads of addresses 1 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_in | input | DATA_W | Event pulses from the datapath, one bit per cause |
| irq_o | output | 1 | Interrupt request, high while an enabled cause is pending |

## Verification
On every cycle, the assertions check the following:
- Reserved cause and mask bits stay at zero.
- Mask-set and mask-clear writes take effect in the next cycle.
- An event always lands in the cause register, even when a clearing write hits the same bit.
- A clearing read with no competing input empties the cause register.
- A rising interrupt is backed by an enabled cause.
- The status bit in the read data matches the interrupt line.

Some behaviour is only shown by the bench scenarios. These are the complete per-bit sweep of which positions exist, and how the read data looks after each kind of access. The bench also shows that a read made while the interrupt is high does not clear anything, and that a masked injection stays silent until its mask bit is set.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // Register word addresses on the strobe bus.
  typedef enum logic [1:0] {
    ADR_CAUSE = 2'd0,
    ADR_CSET  = 2'd1,
    ADR_MSET  = 2'd2,
    ADR_MCLR  = 2'd3
  } reg_adr_e;

  // Cause bit positions decoded by software.
  localparam int unsigned CB_TX_WB     = 0;
  localparam int unsigned CB_TX_EMPTY  = 1;
  localparam int unsigned CB_LINK      = 2;
  localparam int unsigned CB_RX_MINTH  = 4;
  localparam int unsigned CB_RX_OVR    = 6;
  localparam int unsigned CB_RX_TIMER  = 7;
  localparam int unsigned CB_MGMT_DONE = 9;
  localparam int unsigned CB_TX_LOWTH  = 15;
  localparam int unsigned CB_RX_SMALL  = 16;
  localparam int unsigned CB_RX_ACK    = 17;

  localparam logic [31:0] CAUSE_VALID =
      (32'd1 << CB_TX_WB)    | (32'd1 << CB_TX_EMPTY) | (32'd1 << CB_LINK) |
      (32'd1 << CB_RX_MINTH) | (32'd1 << CB_RX_OVR)   | (32'd1 << CB_RX_TIMER) |
      (32'd1 << CB_MGMT_DONE)| (32'd1 << CB_TX_LOWTH) | (32'd1 << CB_RX_SMALL) |
      (32'd1 << CB_RX_ACK);
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cause_q,
  input  logic [DATA_W-1:0] mask_q,
  input  logic              irq_q,
  output logic [DATA_W-1:0] w1c_cause,
  output logic [DATA_W-1:0] set_cause,
  output logic [DATA_W-1:0] set_mask,
  output logic [DATA_W-1:0] clr_mask,
  output logic              rd_clear,
  output logic [DATA_W-1:0] rdata_q
);
  import irq_ctrl_pkg::*;

  localparam int unsigned STAT_BIT = DATA_W - 1;

  logic hit_cause, hit_cset, hit_mset, hit_mclr;
  logic [DATA_W-1:0] rd_mux;

  assign hit_cause = (bus_addr == ADDR_W'(ADR_CAUSE));
  assign hit_cset  = (bus_addr == ADDR_W'(ADR_CSET));
  assign hit_mset  = (bus_addr == ADDR_W'(ADR_MSET));
  assign hit_mclr  = (bus_addr == ADDR_W'(ADR_MCLR));

  assign w1c_cause = (bus_wr && hit_cause) ? bus_wdata : '0;
  assign set_cause = (bus_wr && hit_cset)  ? bus_wdata : '0;
  assign set_mask  = (bus_wr && hit_mset)  ? bus_wdata : '0;
  assign clr_mask  = (bus_wr && hit_mclr)  ? bus_wdata : '0;
  assign rd_clear  = bus_rd && hit_cause && !irq_q;

  always_comb begin
    rd_mux = '0;
    if (hit_cause) begin
      rd_mux = cause_q;
      rd_mux[STAT_BIT] = irq_q;
    end else if (hit_mset) begin
      rd_mux = mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  a_r8_status_bit: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_cause) |=> (rdata_q[STAT_BIT] == $past(irq_q)));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata_q));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] mask_q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) mask_q[i] <= 1'b0;
        else     mask_q[i] <= (mask_q[i] | set_mask[i]) & ~clr_mask[i];
      end
    end else begin : g_tied
      assign mask_q[i] = 1'b0;
    end
  end

  a_r1_mask_reserved: assert property (@(posedge clk) disable iff (rst)
    ((mask_q & ~VALID) == '0));

  a_r2_mask_set: assert property (@(posedge clk) disable iff (rst)
    (|(set_mask & VALID)) |=>
      ((mask_q & $past(set_mask & VALID)) == $past(set_mask & VALID)));

  a_r3_mask_clear: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((mask_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_in,
  input  logic [DATA_W-1:0] w1c_cause,
  input  logic [DATA_W-1:0] set_cause,
  input  logic              rd_clear,
  output logic [DATA_W-1:0] cause_q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)           cause_q[i] <= 1'b0;
        else if (rd_clear) cause_q[i] <= evt_in[i] | set_cause[i];
        else               cause_q[i] <= (cause_q[i] & ~w1c_cause[i]) | set_cause[i] | evt_in[i];
      end
    end else begin : g_tied
      assign cause_q[i] = 1'b0;
    end
  end

  a_r1_cause_reserved: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & ~VALID) == '0));

  a_r10_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|(evt_in & VALID)) |=>
      ((cause_q & $past(evt_in & VALID)) == $past(evt_in & VALID)));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clear && evt_in == '0 && set_cause == '0) |=> (cause_q == '0));
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cause_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic              irq_q
);
  localparam int unsigned SRC_W = DATA_W - 1;

  logic pend;
  assign pend = |(cause_q[SRC_W-1:0] & mask_q[SRC_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend;
  end

  a_r7_rise_backed: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(|(cause_q & mask_q)));

  a_r7_fall_backed: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> !$past(|(cause_q[SRC_W-1:0] & mask_q[SRC_W-1:0])));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] VALID = irq_ctrl_pkg::CAUSE_VALID
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_in,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] LIVE = VALID & ~(DATA_W'(1) << (DATA_W - 1));

  logic [DATA_W-1:0] cause_q, mask_q;
  logic [DATA_W-1:0] w1c_cause, set_cause, set_mask, clr_mask;
  logic rd_clear;
  logic irq_q;

  irq_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cause_q(cause_q), .mask_q(mask_q), .irq_q(irq_q),
    .w1c_cause(w1c_cause), .set_cause(set_cause),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .rd_clear(rd_clear), .rdata_q(bus_rdata)
  );

  irq_mask_reg #(.DATA_W(DATA_W), .VALID(LIVE)) u_mask (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
    .mask_q(mask_q)
  );

  irq_cause_reg #(.DATA_W(DATA_W), .VALID(LIVE)) u_cause (
    .clk(clk), .rst(rst), .evt_in(evt_in), .w1c_cause(w1c_cause),
    .set_cause(set_cause), .rd_clear(rd_clear), .cause_q(cause_q)
  );

  irq_line #(.DATA_W(DATA_W)) u_line (
    .clk(clk), .rst(rst), .cause_q(cause_q), .mask_q(mask_q), .irq_q(irq_q)
  );

  assign irq_o = irq_q;

  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && bus_rdata == '0));
endmodule

// File: tb/sim_irq_cause_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cause_ctrl;
  localparam logic [31:0] VMASK = 32'h0003_82D7;
  localparam logic [1:0] A_CAUSE = 2'd0, A_CSET = 2'd1, A_MSET = 2'd2, A_MCLR = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, evt_in = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_cause_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] v);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic scrub();
    wr(A_CAUSE, 32'hFFFF_FFFF);
    wr(A_MCLR, 32'hFFFF_FFFF);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R11 irq in reset", {31'd0, irq_o}, 32'd0);
    check("R11 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0;
    tick();
    rd_chk(A_CAUSE, 32'd0, "R11 cause after reset");
    rd_chk(A_MSET, 32'd0, "R11 mask after reset");

    // Per-bit sweep over all 32 positions
    for (int b = 0; b < 32; b++) begin
      logic [31:0] one, e;
      logic v;
      one = 32'd1 << b;
      v = VMASK[b];
      e = v ? one : 32'd0;
      wr(A_MSET, one);
      rd_chk(A_MSET, e, $sformatf("R2/R1 mask bit %0d", b));
      pulse(one);
      tick();
      check($sformatf("R4/R7 irq after event bit %0d", b), {31'd0, irq_o}, {31'd0, v});
      rd_chk(A_CAUSE, {v, 31'd0} | e, $sformatf("R4/R8 cause read bit %0d", b));
      wr(A_CAUSE, one);
      tick();
      check($sformatf("R5 irq after clear bit %0d", b), {31'd0, irq_o}, 32'd0);
      rd_chk(A_CAUSE, 32'd0, $sformatf("R5 cause cleared bit %0d", b));
      wr(A_MCLR, one);
      rd_chk(A_MSET, 32'd0, $sformatf("R3 mask cleared bit %0d", b));
      wr(A_CSET, one);
      tick();
      check($sformatf("R6 masked inject silent bit %0d", b), {31'd0, irq_o}, 32'd0);
      rd_chk(A_CAUSE, e, $sformatf("R6 injected cause bit %0d", b));
      rd_chk(A_CAUSE, 32'd0, $sformatf("R9 read cleared bit %0d", b));
      wr(A_MSET, one);
      wr(A_CSET, one);
      tick();
      check($sformatf("R6 enabled inject irq bit %0d", b), {31'd0, irq_o}, {31'd0, v});
      scrub();
    end

    // Partial mask: enable bits 0 and 2, events on 0..2
    wr(A_MSET, 32'h5);
    pulse(32'h7);
    tick();
    check("R7 irq partial mask", {31'd0, irq_o}, 32'd1);
    rd_chk(A_CAUSE, 32'h8000_0007, "R9 read while high keeps causes");
    rd_chk(A_CAUSE, 32'h8000_0007, "R9 second read while high");
    wr(A_CAUSE, 32'h0);
    rd_chk(A_CAUSE, 32'h8000_0007, "R5 zero write no effect");
    wr(A_CAUSE, 32'h8000_0000);
    tick();
    check("R5 bit31 write keeps irq", {31'd0, irq_o}, 32'd1);
    wr(A_CAUSE, 32'h5);
    tick();
    check("R7 irq drops with masked cause left", {31'd0, irq_o}, 32'd0);
    rd_chk(A_CAUSE, 32'h2, "R7 masked cause remains");
    rd_chk(A_CAUSE, 32'h0, "R9 low read cleared all");
    scrub();

    // Event against clearing write on the same bit
    wr(A_MSET, 32'h10);
    pulse(32'h10);
    evt_in = 32'h10;
    bus_wr = 1'b1; bus_addr = A_CAUSE; bus_wdata = 32'h10;
    tick();
    evt_in = '0; bus_wr = 1'b0; bus_wdata = '0;
    tick();
    check("R10 irq stays with collision", {31'd0, irq_o}, 32'd1);
    rd_chk(A_CAUSE, 32'h8000_0010, "R10 event beats clear");
    scrub();

    // Reserved events and other read addresses
    wr(A_MSET, 32'hFFFF_FFFF);
    rd_chk(A_MSET, VMASK, "R1 mask reserved zero");
    pulse(~VMASK);
    tick();
    check("R1 reserved events no irq", {31'd0, irq_o}, 32'd0);
    rd_chk(A_CAUSE, 32'd0, "R1 reserved causes zero");
    pulse(32'h0002_0000);
    rd_chk(A_CSET, 32'd0, "R12 cause-set reads zero");
    rd_chk(A_MCLR, 32'd0, "R12 mask-clear reads zero");
    tick();
    check("R12 rdata held", bus_rdata, 32'd0);
    rd_chk(A_CAUSE, 32'h8002_0000, "R8 status with rx ack");
    scrub();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule